// File: doc/BRIEF.md
# MDIO Station Management Controller

A master for the two-wire PHY management bus. It runs Clause 22 read and write frames to external PHYs. The MDC clock comes from a divider of the system clock, and MDIO is a single bidirectional data line. On chip, the line is presented as an output value, an output enable and an input.

Software sees six 32-bit registers on a simple word-addressed bus. Writes take effect on the clock edge. Reads are combinational.

A write frame starts as soon as the write-data register is written. A read frame starts when bit 0 of the command register goes from 0 to 1. Software polls the indication register for the busy and not-valid flags, then takes the read result from the result register. A configuration write with its top bit set aborts the management logic and returns it to idle.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The register word offsets are: configuration 0, command 1, target 2, write-data 3, read-result 4, indication 5. The target register holds the PHY address in bits 12:8 and the register number in bits 4:0. All other target bits read back as 0.
- R2: Writing the write-data register while idle starts a frame in the next cycle. The frame is 32 ones, then 01, then op 01, then the PHY address, register number, 10 and the 16 low data bits, all MSB first (64 MDC periods).
- R3: A read frame (op 10) starts only when a command write moves the stored bit 0 from 0 to 1. Writing 1 while the bit is already 1 starts nothing.
- R4: Indication bit 0 (busy) reads 1 from the cycle after a launch until the frame's final MDC falling edge, and reads 0 otherwise.
- R5: Indication bit 2 (not-valid) is set when a read launches and is cleared when the result is latched. The read result register then holds in bits 15:0 the 16 bits sampled on the last 16 MDC rising edges.
- R6: MDIO changes only while MDC is low. During a read, the output enable is low from the turnaround through the last data bit. The output enable is high for every other frame bit.
- R7: The MDC period is 4*(n+1) system clocks, where n is configuration bits 2:0 (reset value 7). MDC is low whenever the block is idle.
- R8: A write-data write or a command 0-to-1 edge that arrives while busy is ignored. The running frame is unchanged and no second frame follows.
- R9: A configuration write with bit 31 set aborts any frame. From the next cycle busy and not-valid are 0, MDC is low and the output enable is low. Bits 2:0 of that same write load the divider code.
- R10: After reset the configuration reads 7, indication reads 0, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mdc_o | output | 1 | Management clock to PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest situations to reach are those that need a second request or a soft reset to land in the middle of a running frame. The whole bench is aimed at them.

For these cases the bench issues the second write-data write and a full command 0-then-1 sequence immediately after a launch, while busy is high. It then confirms that the 64 bits captured on the PHY side match the first frame only.

For the abort, the bench waits a few hundred cycles into a slow frame before writing the reset bit. It then checks that MDC stops and that a fresh frame completes normally afterwards.

A behavioural PHY drives turnaround and data bits on MDC falling edges, so the read path and the release of the output enable are observed at the pins.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int BUS_W     = 32;
  localparam int RA_W      = 3;
  localparam int PHY_AW    = 5;
  localparam int REG_AW    = 5;
  localparam int DW        = 16;
  localparam int DIV_W     = 3;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_AW + REG_AW + 2 + DW;
  localparam int TA_IDX    = FRAME_LEN - DW - 2;
  localparam int DATA_IDX  = FRAME_LEN - DW;

  localparam logic [RA_W-1:0] OFS_CFG = 3'd0;
  localparam logic [RA_W-1:0] OFS_CMD = 3'd1;
  localparam logic [RA_W-1:0] OFS_TGT = 3'd2;
  localparam logic [RA_W-1:0] OFS_WD  = 3'd3;
  localparam logic [RA_W-1:0] OFS_RD  = 3'd4;
  localparam logic [RA_W-1:0] OFS_IND = 3'd5;

  localparam logic [1:0] SOF    = 2'b01;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;
  localparam logic [1:0] TA_WR  = 2'b10;
  localparam logic [1:0] TA_RD  = 2'b11;

  localparam int PHY_LSB   = 8;
  localparam int ABORT_BIT = 31;
  localparam int BUSY_BIT  = 0;
  localparam int NV_BIT    = 2;
  localparam logic [DIV_W-1:0] DIV_RST = '1;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;
  logic             mdc_q;
  logic             wrap;

  // half period = 2*(n+1) system clocks
  assign half_m1 = {code_i, 1'b1};
  assign wrap    = run_i && !clr_i && (cnt_q == half_m1);
  assign rise_o  = wrap && !mdc_q;
  assign fall_o  = wrap && mdc_q;
  assign mdc_o   = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i || clr_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_wr_i,
  input  logic              start_rd_i,
  input  logic [PHY_AW-1:0] phy_i,
  input  logic [REG_AW-1:0] reg_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              nvalid_o,
  output logic [DW-1:0]     rdata_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_I     = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] DATA_I   = IDX_W'(DATA_IDX);

  logic [FRAME_LEN-1:0] sh_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 busy_q, rd_q, nv_q;
  logic [DW-1:0]        rsh_q, rdata_q;
  logic [FRAME_LEN-1:0] frame_d;
  logic                 launch;

  assign launch  = start_wr_i || start_rd_i;
  assign frame_d = {{PRE_LEN{1'b1}}, SOF,
                    start_rd_i ? OP_RD : OP_WR,
                    phy_i, reg_i,
                    start_rd_i ? TA_RD : TA_WR,
                    start_rd_i ? {DW{1'b1}} : wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '1;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      nv_q    <= 1'b0;
      rsh_q   <= '0;
      rdata_q <= '0;
    end else if (abort_i) begin
      sh_q   <= '1;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      nv_q   <= 1'b0;
    end else if (!busy_q) begin
      if (launch) begin
        sh_q   <= frame_d;
        idx_q  <= '0;
        busy_q <= 1'b1;
        rd_q   <= start_rd_i;
        nv_q   <= start_rd_i;
      end
    end else begin
      if (rise_i && rd_q && idx_q >= DATA_I)
        rsh_q <= {rsh_q[DW-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          sh_q   <= '1;
          if (rd_q) begin
            rdata_q <= rsh_q;
            nv_q    <= 1'b0;
          end
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign nvalid_o  = nv_q;
  assign rdata_o   = rdata_q;
  assign mdio_o    = sh_q[FRAME_LEN-1];
  assign mdio_oe_o = busy_q && !(rd_q && idx_q >= TA_I);
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  input  logic              busy_i,
  input  logic              nvalid_i,
  input  logic [DW-1:0]     rdata_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [PHY_AW-1:0] phy_o,
  output logic [REG_AW-1:0] reg_o,
  output logic              start_wr_o,
  output logic              start_rd_o,
  output logic              abort_o
);
  logic [DIV_W-1:0]  div_q;
  logic              cmd_q;
  logic [PHY_AW-1:0] phy_q;
  logic [REG_AW-1:0] reg_q;
  logic [DW-1:0]     wd_q;
  logic wr_cfg, wr_cmd, wr_tgt, wr_wd;

  assign wr_cfg = reg_we_i && reg_addr_i == OFS_CFG;
  assign wr_cmd = reg_we_i && reg_addr_i == OFS_CMD;
  assign wr_tgt = reg_we_i && reg_addr_i == OFS_TGT;
  assign wr_wd  = reg_we_i && reg_addr_i == OFS_WD;

  assign abort_o    = wr_cfg && reg_wdata_i[ABORT_BIT];
  assign start_wr_o = wr_wd && !busy_i;
  assign start_rd_o = wr_cmd && reg_wdata_i[0] && !cmd_q && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_RST;
      cmd_q <= 1'b0;
      phy_q <= '0;
      reg_q <= '0;
      wd_q  <= '0;
    end else begin
      if (wr_cfg) div_q <= reg_wdata_i[DIV_W-1:0];
      if (wr_cmd) cmd_q <= reg_wdata_i[0];
      if (wr_tgt) begin
        phy_q <= reg_wdata_i[PHY_LSB +: PHY_AW];
        reg_q <= reg_wdata_i[REG_AW-1:0];
      end
      if (wr_wd)  wd_q  <= reg_wdata_i[DW-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_CFG: reg_rdata_o[DIV_W-1:0] = div_q;
      OFS_CMD: reg_rdata_o[0] = cmd_q;
      OFS_TGT: begin
        reg_rdata_o[PHY_LSB +: PHY_AW] = phy_q;
        reg_rdata_o[REG_AW-1:0]        = reg_q;
      end
      OFS_WD:  reg_rdata_o[DW-1:0] = wd_q;
      OFS_RD:  reg_rdata_o[DW-1:0] = rdata_i;
      OFS_IND: begin
        reg_rdata_o[BUSY_BIT] = busy_i;
        reg_rdata_o[NV_BIT]   = nvalid_i;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign div_o = div_q;
  assign phy_o = phy_q;
  assign reg_o = reg_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [RA_W-1:0]  reg_addr_i,
  input  logic [BUS_W-1:0] reg_wdata_i,
  output logic [BUS_W-1:0] reg_rdata_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  logic [DIV_W-1:0]  div_w;
  logic [PHY_AW-1:0] phy_w;
  logic [REG_AW-1:0] reg_w;
  logic [DW-1:0]     rdata_w;
  logic start_wr_w, start_rd_w, abort_w;
  logic busy_w, nv_w, rise_w, fall_w;

  mdio_regfile u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy_w), .nvalid_i(nv_w), .rdata_i(rdata_w),
    .div_o(div_w), .phy_o(phy_w), .reg_o(reg_w),
    .start_wr_o(start_wr_w), .start_rd_o(start_rd_w), .abort_o(abort_w)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk_i, .rst_ni, .run_i(busy_w), .clr_i(abort_w), .code_i(div_w),
    .mdc_o, .rise_o(rise_w), .fall_o(fall_w)
  );

  mdio_frame_eng u_eng (
    .clk_i, .rst_ni, .abort_i(abort_w),
    .start_wr_i(start_wr_w), .start_rd_i(start_rd_w),
    .phy_i(phy_w), .reg_i(reg_w), .wdata_i(reg_wdata_i[DW-1:0]),
    .rise_i(rise_w), .fall_i(fall_w), .mdio_i,
    .busy_o(busy_w), .nvalid_o(nv_w), .rdata_o(rdata_w),
    .mdio_o, .mdio_oe_o
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_mgmt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [RA_W-1:0]  reg_addr_i,
  input logic [BUS_W-1:0] reg_wdata_i,
  input logic             mdc_o,
  input logic             mdio_o,
  input logic             mdio_oe_o,
  input logic             busy_w,
  input logic             nv_w
);
  // R4, R7: idle means MDC low and line released
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_w |-> (!mdc_o && !mdio_oe_o));

  a_r5_nv_within_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_w |-> busy_w);

  a_r6_stable_mdc_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  a_r9_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_CFG && reg_wdata_i[ABORT_BIT])
      |=> (!busy_w && !nv_w && !mdc_o));

  a_r8_busy_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_w && mdc_o) |=> (busy_w || !mdc_o));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
  .mdc_o, .mdio_o, .mdio_oe_o, .busy_w, .nv_w
);

// File: tb/sim_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, moe, mdi;
  logic        phy_drv = 1'b1;

  int nchk = 0, nerr = 0;
  int rcnt = 0;
  bit rd_mode = 1'b0, oe_bad = 1'b0;
  logic [15:0] resp = '0;
  logic [63:0] cap = '0;
  realtime t0 = 0, t1 = 0;

  localparam logic [2:0] A_CFG = 0, A_CMD = 1, A_TGT = 2, A_WD = 3, A_RD = 4, A_IND = 5;

  always #4 clk = ~clk;

  assign mdi = moe ? mdo : phy_drv;

  mdio_mgmt_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(mdi)
  );

  // PHY model: capture on MDC rise, drive on MDC fall
  always @(posedge mdc) begin
    if (rcnt < 64) cap[63-rcnt] = mdi;
    if (rcnt == 0) t0 = $realtime;
    if (rcnt == 1) t1 = $realtime;
    if (rd_mode && rcnt >= 46 && moe) oe_bad = 1'b1;
    if (!rd_mode && moe == 1'b0) oe_bad = 1'b1;
    if (rd_mode && rcnt < 46 && !moe) oe_bad = 1'b1;
    rcnt = rcnt + 1;
  end

  always @(negedge mdc) begin
    if (rd_mode && rcnt == 47) phy_drv = 1'b0;
    else if (rd_mode && rcnt >= 48 && rcnt < 64) phy_drv = resp[63-rcnt];
    else phy_drv = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(A_IND, v);
      if (!v[0]) return;
      @(negedge clk);
    end
    chk(1'b0, "R4 busy never cleared", 1, 0);
  endtask

  function automatic logic [63:0] exp_frame(bit r, logic [4:0] p, logic [4:0] g, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, r ? 2'b10 : 2'b01, p, g, r ? 2'b11 : 2'b10, r ? 16'hFFFF : d};
  endfunction

  task automatic txn(input bit r, input logic [4:0] p, input logic [4:0] g,
                     input logic [15:0] d, input int code);
    logic [31:0] v;
    logic [63:0] e;
    wr(A_CFG, code);
    wr(A_TGT, {19'b0, p, 3'b0, g});
    rcnt = 0; rd_mode = r; resp = d; oe_bad = 1'b0;
    if (r) begin wr(A_CMD, 0); wr(A_CMD, 1); end
    else wr(A_WD, {16'b0, d});
    rd(A_IND, v);
    chk(v == (r ? 32'd5 : 32'd1), r ? "R5 nv+busy after read launch" : "R4 busy after write launch", v, r ? 5 : 1);
    wait_idle();
    e = exp_frame(r, p, g, d);
    chk(rcnt == 64, "R2 64 MDC periods per frame", rcnt, 64);
    if (r) chk(cap[63:18] == e[63:18], "R3 read frame header", cap, e);
    else   chk(cap == e, "R2 write frame bits", cap, e);
    chk(!oe_bad, "R6 output enable per bit", oe_bad, 0);
    chk(int'(t1 - t0) == 32 * (code + 1), "R7 MDC period", int'(t1 - t0), 32 * (code + 1));
    if (r) begin
      rd(A_RD, v);
      chk(v == {16'b0, d}, "R5 read result", v, d);
      rd(A_IND, v);
      chk(v == 0, "R5 nv cleared", v, 0);
    end
    rd_mode = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    int snap;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(A_CFG, v); chk(v == 7, "R10 cfg reset", v, 7);
    rd(A_IND, v); chk(v == 0, "R10 ind reset", v, 0);
    chk(mdc == 0 && moe == 0, "R10 mdc/oe idle", {mdc, moe}, 0);

    // R1 target field masking
    wr(A_TGT, 32'hFFFF_FFFF);
    rd(A_TGT, v); chk(v == 32'h1F1F, "R1 target readback", v, 32'h1F1F);

    // directed frames, extremes of fields and divider
    txn(1'b0, 5'h1F, 5'h00, 16'hA5C3, 0);
    txn(1'b1, 5'h00, 5'h1F, 16'h8001, 1);
    txn(1'b0, 5'h15, 5'h0A, 16'h0000, 7);
    txn(1'b1, 5'h0A, 5'h15, 16'hFFFF, 3);

    // R3 repeat 1 on command starts nothing
    rcnt = 0;
    wr(A_CMD, 1);
    rd(A_IND, v); chk(v == 0, "R3 no launch when bit already 1", v, 0);
    repeat (40) @(negedge clk);
    chk(rcnt == 0, "R3 no MDC activity", rcnt, 0);

    // R8 requests during busy ignored
    wr(A_CFG, 0);
    wr(A_TGT, {19'b0, 5'h03, 3'b0, 5'h04});
    rcnt = 0; rd_mode = 1'b0; oe_bad = 1'b0;
    wr(A_WD, 32'h1234);
    wr(A_WD, 32'hBEEF);
    wr(A_CMD, 0); wr(A_CMD, 1);
    wait_idle();
    chk(cap == exp_frame(1'b0, 5'h03, 5'h04, 16'h1234), "R8 frame unchanged", cap,
        exp_frame(1'b0, 5'h03, 5'h04, 16'h1234));
    repeat (60) @(negedge clk);
    chk(rcnt == 64, "R8 no follow-on frame", rcnt, 64);
    rd(A_IND, v); chk(v == 0, "R8 no read pending", v, 0);

    // R9 abort mid-frame
    wr(A_CFG, 7);
    rcnt = 0;
    wr(A_WD, 32'h5555);
    repeat (300) @(negedge clk);
    wr(A_CFG, 32'h8000_0002);
    rd(A_IND, v); chk(v == 0, "R9 busy cleared by abort", v, 0);
    chk(mdc == 0 && moe == 0, "R9 mdc/oe after abort", {mdc, moe}, 0);
    rd(A_CFG, v); chk(v == 2, "R9 divider loaded on abort", v, 2);
    snap = rcnt;
    repeat (50) @(negedge clk);
    chk(rcnt == snap, "R9 MDC stopped", rcnt, snap);
    txn(1'b1, 5'h11, 5'h02, 16'h3C3C, 2);

    // constrained random frames
    for (int i = 0; i < 8; i++) begin
      txn(1'($urandom_range(0, 1)), 5'($urandom), 5'($urandom), 16'($urandom),
          int'($urandom_range(0, 2)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule